// File: doc/BRIEF.md
# Address-Matching Framed Packet Receiver

This block sits on one byte-wide subnet and watches every word that passes, one word per clock. Packets are framed by a start code and a stop code. The body of a packet is a run of 7-bit chunks. First comes the destination address, with the most significant chunk first. Next comes the source address in the same order. Last comes the payload, with the least significant chunk first. Words outside a packet carry no information and are skipped.

The receiver assembles the destination, the source and the payload in staging registers. When a stop code arrives right after the last payload chunk, the receiver compares the destination with the node address on `node_addr`. A match copies the payload and the source into the output registers and raises a one-clock `msg_valid` strobe.

A packet with the wrong number of chunks is dropped. So is a packet in which another control word appears before the stop position. After a drop the receiver waits for the next start code. A start code met anywhere begins a fresh header. The receiver expects a fixed number of payload chunks, ceil(`PAY_W`/7). A build parameter chooses between two forms of the address compare. One is combinational at the stop word. The other is a registered compare that keeps the equality tree off the commit path.

Top module: `pkt_addr_rx`

## Requirements
- R1: After reset, `msg_valid` is 0 and `msg_data` and `msg_src` are all zeros.
- R2: A word with bit 7 set is a data chunk carrying its bits [6:0]. A word with bit 7 clear is a control word: 8'h00 is idle, 8'h01 is start and 8'h40 is stop. Outside a packet, every word other than start has no effect on the outputs.
- R3: The ADDR_W/7 chunks after start form the destination, and the next ADDR_W/7 chunks form the source. In each address the first chunk holds the most significant 7 bits. On a commit, `msg_src` equals the received source.
- R4: The payload is ceil(PAY_W/7) chunks long. Chunk k, counting from 0 as the first payload chunk, supplies bits [7k+6:7k]. `msg_data` takes the low PAY_W bits.
- R5: Suppose a stop word immediately follows the last payload chunk and the destination equals `node_addr`. Then `msg_valid` is 1 in the cycle after the clock edge that samples the stop word, and only in that cycle. `msg_data` and `msg_src` change in that same cycle.
- R6: A packet whose destination differs from `node_addr` in any bit gives no strobe and leaves both outputs unchanged.
- R7: A stop word before the last payload chunk, or a data chunk where the stop word is due, drops the packet: no strobe and no output change. Words that follow are ignored until the next start.
- R8: A start word inside a packet drops the partial packet and begins a new header. A complete packet that follows it commits normally.
- R9: An idle or any other non-start control word before the stop position drops the packet, with no strobe and no output change.
- R10: A start word directly after a stop word is accepted, so back-to-back packets each commit. Between commits the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | ADDR_W | This node's address, held stable while packets arrive |
| rx_word | input | 8 | Subnet word, one per clock |
| msg_valid | output | 1 | One-clock strobe on an accepted message |
| msg_data | output | PAY_W | Payload of the last accepted message |
| msg_src | output | ADDR_W | Source address of the last accepted message |

## Verification
The hardest cases to reach are the ones where the packet is almost right. These include a destination that differs from the node address in only its lowest or highest bit, a packet one chunk short or one chunk long, and a restart after three destination chunks, where the partial packet must not leak any chunks into the one that follows. Directed frames build each of these cases on purpose. A seeded random loop then mixes matching and near-miss addresses, random payloads and every kind of corruption, with junk words between packets. Back-to-back packets with no idle between stop and start are also driven, and the bench counts the strobes to catch a pulse that is too long or one that is missing.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
   localparam int CHUNK_W = 7;

   localparam logic [7:0] CODE_IDLE  = 8'h00;
   localparam logic [7:0] CODE_START = 8'h01;
   localparam logic [7:0] CODE_STOP  = 8'h40;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_DEST,
      ST_SRC,
      ST_PAY,
      ST_TAIL
   } rx_state_t;

   typedef enum logic [1:0] {
      W_DATA,
      W_START,
      W_STOP,
      W_OTHER
   } word_kind_t;

   function automatic int chunks_for(input int width);
      return (width + CHUNK_W - 1) / CHUNK_W;
   endfunction
endpackage

// File: rtl/pkt_rx_classify.sv
module pkt_rx_classify
   import pkt_rx_pkg::*;
(
   input  logic [7:0]         word_i,
   output word_kind_t         kind_o,
   output logic [CHUNK_W-1:0] chunk_o
);
   always_comb begin
      if (word_i[7])                 kind_o = W_DATA;
      else if (word_i == CODE_START) kind_o = W_START;
      else if (word_i == CODE_STOP)  kind_o = W_STOP;
      else                           kind_o = W_OTHER;
   end

   assign chunk_o = word_i[CHUNK_W-1:0];
endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
   import pkt_rx_pkg::*;
#(
   parameter int ADDR_CHUNKS = 4,
   parameter int PAY_CHUNKS  = 5,
   parameter int IDX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  word_kind_t       kind_i,
   output logic             dest_en_o,
   output logic             src_en_o,
   output logic             pay_en_o,
   output logic [IDX_W-1:0] pay_idx_o,
   output logic             stop_ok_o
);
   localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(ADDR_CHUNKS - 1);
   localparam logic [IDX_W-1:0] LAST_PAY  = IDX_W'(PAY_CHUNKS - 1);

   rx_state_t        state_q, state_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      dest_en_o = 1'b0;
      src_en_o  = 1'b0;
      pay_en_o  = 1'b0;
      stop_ok_o = 1'b0;
      if (kind_i == W_START) begin
         state_d = ST_DEST;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            ST_HUNT: ;
            ST_DEST: begin
               if (kind_i == W_DATA) begin
                  dest_en_o = 1'b1;
                  if (cnt_q == LAST_ADDR) begin
                     state_d = ST_SRC;
                     cnt_d   = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end else begin
                  state_d = ST_HUNT;
               end
            end
            ST_SRC: begin
               if (kind_i == W_DATA) begin
                  src_en_o = 1'b1;
                  if (cnt_q == LAST_ADDR) begin
                     state_d = ST_PAY;
                     cnt_d   = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end else begin
                  state_d = ST_HUNT;
               end
            end
            ST_PAY: begin
               if (kind_i == W_DATA) begin
                  pay_en_o = 1'b1;
                  if (cnt_q == LAST_PAY) begin
                     state_d = ST_TAIL;
                     cnt_d   = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end else begin
                  state_d = ST_HUNT;
               end
            end
            ST_TAIL: begin
               stop_ok_o = (kind_i == W_STOP);
               state_d   = ST_HUNT;
            end
            default: state_d = ST_HUNT;
         endcase
      end
   end

   assign pay_idx_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   // R2: outside a packet only a start word moves the parser
   a_r2_hunt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT && kind_i != W_START) |=> state_q == ST_HUNT);

   // R8: a start word anywhere leads to destination parsing
   a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == W_START) |=> (state_q == ST_DEST && cnt_q == '0));

   // R7: a data chunk where the stop word is due drops the packet
   a_r7_tail_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TAIL && kind_i == W_DATA) |=> state_q == ST_HUNT);

   // R9: an idle inside the body drops the packet
   a_r9_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_HUNT && kind_i == W_OTHER) |=> state_q == ST_HUNT);
endmodule

// File: rtl/pkt_rx_shift.sv
module pkt_rx_shift
   import pkt_rx_pkg::*;
#(
   parameter int W = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic [CHUNK_W-1:0] chunk_i,
   output logic [W-1:0]       q_o
);
   generate
      if (W > CHUNK_W) begin : g_wide
         always_ff @(posedge clk) begin
            if (!rst_n)    q_o <= '0;
            else if (en_i) q_o <= {q_o[W-CHUNK_W-1:0], chunk_i};
         end
      end else begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)    q_o <= '0;
            else if (en_i) q_o <= chunk_i[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/pkt_rx_payload.sv
module pkt_rx_payload
   import pkt_rx_pkg::*;
#(
   parameter int PAY_W = 32,
   parameter int IDX_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [CHUNK_W-1:0] chunk_i,
   output logic [PAY_W-1:0]   data_o
);
   localparam int PC = chunks_for(PAY_W);

   for (genvar k = 0; k < PC; k++) begin : g_slot
      localparam int SW = (k == PC - 1) ? (PAY_W - CHUNK_W * (PC - 1)) : CHUNK_W;
      logic [SW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                             slot_q <= '0;
         else if (wr_i && idx_i == IDX_W'(k))    slot_q <= chunk_i[SW-1:0];
      end
      assign data_o[k*CHUNK_W +: SW] = slot_q;
   end

   // R4: a write never targets a slot beyond the payload
   always_comb begin
      if (rst_n && wr_i) begin
         a_r4_idx_range: assert (int'(idx_i) < PC);
      end
   end
endmodule

// File: rtl/pkt_addr_rx.sv
module pkt_addr_rx
   import pkt_rx_pkg::*;
#(
   parameter int ADDR_W      = 28,
   parameter int PAY_W       = 32,
   parameter bit EARLY_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic [7:0]        rx_word,
   output logic              msg_valid,
   output logic [PAY_W-1:0]  msg_data,
   output logic [ADDR_W-1:0] msg_src
);
   localparam int ADDR_CHUNKS = chunks_for(ADDR_W);
   localparam int PAY_CHUNKS  = chunks_for(PAY_W);
   localparam int MAXC        = (ADDR_CHUNKS > PAY_CHUNKS) ? ADDR_CHUNKS : PAY_CHUNKS;
   localparam int IDX_W       = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (ADDR_W < CHUNK_W) begin : g_bad_addr
      $error("pkt_addr_rx: ADDR_W must be at least one chunk");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("pkt_addr_rx: PAY_W must be positive");
   end

   word_kind_t         kind;
   logic [CHUNK_W-1:0] chunk;
   logic               dest_en, src_en, pay_en, stop_ok;
   logic [IDX_W-1:0]   pay_idx;
   logic [ADDR_W-1:0]  dest_q, src_q;
   logic [PAY_W-1:0]   pay_stage;
   logic               dest_hit;
   logic               commit;

   pkt_rx_classify i_classify (
      .word_i  (rx_word),
      .kind_o  (kind),
      .chunk_o (chunk)
   );

   pkt_rx_ctrl #(
      .ADDR_CHUNKS (ADDR_CHUNKS),
      .PAY_CHUNKS  (PAY_CHUNKS),
      .IDX_W       (IDX_W)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind_i    (kind),
      .dest_en_o (dest_en),
      .src_en_o  (src_en),
      .pay_en_o  (pay_en),
      .pay_idx_o (pay_idx),
      .stop_ok_o (stop_ok)
   );

   pkt_rx_shift #(.W(ADDR_W)) i_dest (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (dest_en),
      .chunk_i (chunk),
      .q_o     (dest_q)
   );

   pkt_rx_shift #(.W(ADDR_W)) i_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (src_en),
      .chunk_i (chunk),
      .q_o     (src_q)
   );

   pkt_rx_payload #(.PAY_W(PAY_W), .IDX_W(IDX_W)) i_payload (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (pay_en),
      .idx_i   (pay_idx),
      .chunk_i (chunk),
      .data_o  (pay_stage)
   );

   generate
      if (EARLY_MATCH) begin : g_match_reg
         logic hit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= (dest_q == node_addr);
         end
         assign dest_hit = hit_q;
      end else begin : g_match_comb
         assign dest_hit = (dest_q == node_addr);
      end
   endgenerate

   assign commit = stop_ok && dest_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_data  <= '0;
         msg_src   <= '0;
      end else begin
         msg_valid <= commit;
         if (commit) begin
            msg_data <= pay_stage;
            msg_src  <= src_q;
         end
      end
   end

   // R5: the strobe lasts a single clock
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);

   // R5: the strobe only follows a stop word
   a_r5_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(rx_word) == CODE_STOP);

   // R6: a commit only happens for this node's destination
   a_r6_own_address: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(dest_q) == $past(node_addr));

   // R10: outputs hold between commits
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |-> ($stable(msg_data) && $stable(msg_src)));
endmodule

// File: tb/test_pkt_addr_rx.sv
module test_pkt_addr_rx;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 28;
   localparam int PW = 32;
   localparam int AC = 4;
   localparam int PC = 5;
   localparam logic [AW-1:0] MY = 28'hA5C3E71;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] node_addr = MY;
   logic [7:0]    rx_word = 8'h00;
   logic          msg_valid;
   logic [PW-1:0] msg_data;
   logic [AW-1:0] msg_src;

   int tests = 0;
   int fails = 0;
   int vcnt  = 0;
   bit done  = 1'b0;
   logic [PW-1:0] exp_data = '0;
   logic [AW-1:0] exp_src  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_addr_rx #(.ADDR_W(AW), .PAY_W(PW), .EARLY_MATCH(1'b1)) i_pkt_addr_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .node_addr (node_addr),
      .rx_word   (rx_word),
      .msg_valid (msg_valid),
      .msg_data  (msg_data),
      .msg_src   (msg_src)
   );

   always @(posedge clk) if (msg_valid) vcnt <= vcnt + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] w);
      @(negedge clk);
      rx_word = w;
   endtask

   task automatic frame(input logic [AW-1:0] d, input logic [AW-1:0] s,
                        input logic [PW-1:0] p, input int mode);
      put(8'h01);
      for (int j = 0; j < AC; j++) put({1'b1, 7'(d >> (7*(AC-1-j)))});
      for (int j = 0; j < AC; j++) begin
         put({1'b1, 7'(s >> (7*(AC-1-j)))});
         if (mode == 3 && j == 1) put(8'h00);
      end
      for (int k = 0; k < PC; k++)
         if (!(mode == 1 && k == PC-1)) put({1'b1, 7'(p >> (7*k))});
      if (mode == 2) put(8'h85);
      put(8'h40);
   endtask

   // mode 0 good, 1 short, 2 long, 3 idle inside, 4 restart then good
   task automatic run_one(input logic [AW-1:0] d, input logic [AW-1:0] s,
                          input logic [PW-1:0] p, input int mode, input string req);
      bit hit;
      hit = (d == MY) && (mode == 0 || mode == 4);
      @(negedge clk);
      vcnt = 0;
      if (mode == 4) begin
         put(8'h01);
         for (int j = 0; j < 3; j++) put({1'b1, 7'($urandom)});
      end
      frame(d, s, p, (mode == 4) ? 0 : mode);
      put(8'h00);
      check(msg_valid == hit, {req, " strobe after stop"}, 64'(msg_valid), 64'(hit));
      if (hit) begin
         exp_data = p;
         exp_src  = s;
      end
      check(msg_data == exp_data, {req, " data"}, 64'(msg_data), 64'(exp_data));
      check(msg_src == exp_src, {req, " source"}, 64'(msg_src), 64'(exp_src));
      put(8'h00);
      check(msg_valid == 1'b0, {req, " R5 pulse width"}, 64'(msg_valid), 64'd0);
      check(vcnt == int'(hit), {req, " strobe count"}, 64'(vcnt), 64'(hit));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 64'd0);
      check(msg_data == '0, "R1 data", 64'(msg_data), 64'd0);
      check(msg_src == '0, "R1 source", 64'(msg_src), 64'd0);

      // R2 junk outside a packet
      vcnt = 0;
      put(8'h40); put(8'h85); put(8'hFF); put(8'h00); put(8'h22); put(8'h40);
      put(8'h00); put(8'h00);
      check(vcnt == 0, "R2 junk strobe count", 64'(vcnt), 64'd0);
      check(msg_data == '0, "R2 junk data", 64'(msg_data), 64'd0);

      run_one(MY, 28'h1234567, 32'hDEADBEEF, 0, "R3 R4 R5 basic");
      run_one(MY, 28'hFFFFFFF, 32'hFFFFFFFF, 0, "R4 all ones");
      run_one(MY, 28'h0000001, 32'h00000000, 0, "R4 all zeros");
      run_one(MY ^ 28'h0000001, 28'h7654321, 32'h11111111, 0, "R6 lsb miss");
      run_one(MY ^ 28'h8000000, 28'h7654321, 32'h22222222, 0, "R6 msb miss");
      run_one(MY, 28'h0ABCDEF, 32'h33333333, 1, "R7 short");
      run_one(MY, 28'h0ABCDEF, 32'h44444444, 2, "R7 long");
      run_one(MY, 28'h0ABCDEF, 32'h55555555, 3, "R9 idle inside");
      run_one(MY, 28'h0FEDCBA, 32'h89ABCDEF, 4, "R8 restart");

      // R10 back-to-back with no idle between stop and start
      @(negedge clk);
      vcnt = 0;
      frame(MY, 28'h0000AAA, 32'hCAFEF00D, 0);
      frame(MY, 28'h0000BBB, 32'h0BADC0DE, 0);
      put(8'h00);
      check(msg_valid == 1'b1, "R10 second strobe", 64'(msg_valid), 64'd1);
      check(msg_data == 32'h0BADC0DE, "R10 data", 64'(msg_data), 64'h0BADC0DE);
      check(msg_src == 28'h0000BBB, "R10 source", 64'(msg_src), 64'hBBB);
      put(8'h00);
      check(vcnt == 2, "R10 strobe count", 64'(vcnt), 64'd2);
      exp_data = 32'h0BADC0DE;
      exp_src  = 28'h0000BBB;

      for (int i = 0; i < 150; i++) begin
         logic [AW-1:0] d;
         int mode;
         int r;
         r = int'($urandom % 3);
         d = (r == 0) ? AW'($urandom) : ((r == 1) ? (MY ^ (28'h1 << ($urandom % AW))) : MY);
         mode = int'($urandom % 5);
         for (int g = int'($urandom % 3); g > 0; g--)
            put(($urandom % 2) ? 8'h00 : {1'b1, 7'($urandom)});
         run_one(d, AW'($urandom), PW'($urandom), mode, "R2 R6 R7 R8 R9 random");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule